// File: doc/BRIEF.md
# Partitioned Counter Overflow Interrupt Controller

This block turns the overflow state of a bank of event counters into one level-sensitive interrupt. Each counter reports a sticky overflow bit and has an interrupt-enable bit. The counter bank is split in two by a programmable boundary. Counters below the boundary form the lower-privilege range. Counters from the boundary up to the top implemented general counter are reserved for the higher-privilege range. Each range has its own global enable. A pending overflow is therefore forwarded only when the enable of the range that owns its counter is set.

Alongside the interrupt, the block publishes three items. The first is the reserved-counter mask. The second is the mask of counters the current execution mode may access. The third is the counter-count value that the current mode should see when it reads its configuration. The top bit of every vector is the dedicated cycle counter. It always belongs to the lower range and is always implemented. The masks and the count value are combinational. The interrupt level is registered. A one-cycle pulse marks each cycle in which the level changes.

The counters themselves live elsewhere: status and enable vectors arrive as plain inputs. There is no streaming data path, so every pin is a plain level-sensitive control or status signal with no valid/ready handshake.

Top module: `pmu_ovf_irq_ctrl`

## Requirements
- R1: `reserved_mask` is all zero when `nested_en` is 0, or when `hpmn` is greater than or equal to `num_impl`.
- R2: Otherwise `reserved_mask` has bits `num_impl-1` down to `hpmn` set and all other bits clear. `hpmn`=0 reserves every implemented general counter. Bit 31 (cycle counter) is never set.
- R3: A counter is pending when its bits in `ovf_status` and `int_enable` are both 1. After each rising clock edge, `irq_level` equals whether any gated pending bit existed before that edge.
- R4: With `low_gen_en`=0, pending bits outside `reserved_mask` (bit 31 included) cannot raise `irq_level`.
- R5: With `high_gen_en`=0, pending bits inside `reserved_mask` cannot raise `irq_level`.
- R6: The implemented mask has bit 31 plus bits `num_impl-1`..0 set (only bit 31 when `num_impl`=0). `access_mask` equals it when `nested_en`=0 or `high_mode`=1.
- R7: When `nested_en`=1 and `high_mode`=0, `access_mask` is the implemented mask with the `reserved_mask` bits cleared.
- R8: `count_field` is `hpmn` when `nested_en`=1 and `high_mode`=0, else `num_impl`.
- R9: `level_changed` is 1 for exactly the cycle in which `irq_level` has just taken a new value, and 0 whenever `irq_level` holds.
- R10: While `rst_n` is low, `irq_level` and `level_changed` are 0 regardless of the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nested_en | input | 1 | Range partitioning active |
| high_mode | input | 1 | Core runs in the higher-privilege mode |
| hpmn | input | 5 | Partition boundary (first reserved counter) |
| num_impl | input | 5 | Number of implemented general counters |
| low_gen_en | input | 1 | Global enable for the lower range |
| high_gen_en | input | 1 | Global enable for the reserved range |
| ovf_status | input | 32 | Per-counter overflow flags, bit 31 = cycle counter |
| int_enable | input | 32 | Per-counter interrupt enables |
| reserved_mask | output | 32 | Counters reserved for the higher range |
| access_mask | output | 32 | Counters accessible in the current mode |
| count_field | output | 5 | Counter count visible to the current mode |
| irq_level | output | 1 | Registered interrupt level |
| level_changed | output | 1 | One-cycle pulse on each level change |

## Verification
The masks and `count_field` have zero latency. `irq_level` and `level_changed` are due on the first rising edge after a stimulus. The bench drives each stimulus on a falling edge and queues the expected values. The monitor then pops and compares every field 1 ns after the following rising edge, so the combinational and registered results are checked together in that one sample. Holding a stimulus for a second cycle queues a second item that expects `level_changed` low.

// File: rtl/pmu_ovf_pkg.sv
package pmu_ovf_pkg;
  localparam int DEF_CNT_W = 32;

  typedef enum logic [0:0] {
    RNG_LOW  = 1'b0,
    RNG_HIGH = 1'b1
  } range_e;

  typedef struct packed {
    logic nested;
    logic high;
  } mode_t;

  function automatic logic guest_view(input mode_t m);
    return m.nested & ~m.high;
  endfunction
endpackage

// File: rtl/pmu_range_decode.sv
module pmu_range_decode
  import pmu_ovf_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W,
  parameter int IDX_W = $clog2(CNT_W)
) (
  input  mode_t              mode,
  input  logic [IDX_W-1:0]   hpmn,
  input  logic [IDX_W-1:0]   num_impl,
  output logic [CNT_W-1:0]   reserved,
  output logic [CNT_W-1:0]   implemented,
  output logic [CNT_W-1:0]   access,
  output logic [IDX_W-1:0]   count_field
);
  localparam int GEN_CNT = CNT_W - 1;

  logic part_on;
  assign part_on = mode.nested & (hpmn < num_impl);

  for (genvar i = 0; i < GEN_CNT; i++) begin : g_gen
    localparam logic [IDX_W:0] IDX = (IDX_W+1)'(i);
    logic is_impl;
    assign is_impl        = IDX < {1'b0, num_impl};
    assign implemented[i] = is_impl;
    assign reserved[i]    = part_on & is_impl & (IDX >= {1'b0, hpmn});
  end

  assign implemented[GEN_CNT] = 1'b1;
  assign reserved[GEN_CNT]    = 1'b0;

  assign access      = guest_view(mode) ? (implemented & ~reserved) : implemented;
  assign count_field = guest_view(mode) ? hpmn : num_impl;
endmodule

// File: rtl/pmu_irq_gate.sv
module pmu_irq_gate
  import pmu_ovf_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic [CNT_W-1:0] ovf,
  input  logic [CNT_W-1:0] inten,
  input  logic [CNT_W-1:0] reserved,
  input  logic             low_en,
  input  logic             high_en,
  output logic [CNT_W-1:0] pending,
  output logic             any
);
  for (genvar i = 0; i < CNT_W; i++) begin : g_bit
    range_e owner;
    logic   range_on;
    assign owner      = reserved[i] ? RNG_HIGH : RNG_LOW;
    assign range_on   = (owner == RNG_HIGH) ? high_en : low_en;
    assign pending[i] = ovf[i] & inten[i] & range_on;
  end

  assign any = |pending;
endmodule

// File: rtl/pmu_irq_level.sv
module pmu_irq_level (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic irq_level,
  output logic level_changed
);
  logic differs;
  assign differs = level_in != irq_level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_level     <= 1'b0;
      level_changed <= 1'b0;
    end else begin
      level_changed <= differs;
      if (differs) irq_level <= level_in;
    end
  end

  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_level == $past(level_in)); // R3
  AST_PULSE_ON_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    level_changed |-> irq_level != $past(irq_level)); // R9
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !level_changed |-> $stable(irq_level)); // R9
endmodule

// File: rtl/pmu_ovf_irq_ctrl.sv
module pmu_ovf_irq_ctrl
  import pmu_ovf_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W,
  parameter int IDX_W = $clog2(CNT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nested_en,
  input  logic             high_mode,
  input  logic [IDX_W-1:0] hpmn,
  input  logic [IDX_W-1:0] num_impl,
  input  logic             low_gen_en,
  input  logic             high_gen_en,
  input  logic [CNT_W-1:0] ovf_status,
  input  logic [CNT_W-1:0] int_enable,
  output logic [CNT_W-1:0] reserved_mask,
  output logic [CNT_W-1:0] access_mask,
  output logic [IDX_W-1:0] count_field,
  output logic             irq_level,
  output logic             level_changed
);
  mode_t            mode;
  logic [CNT_W-1:0] impl_mask;
  logic [CNT_W-1:0] pending;
  logic             any_pending;

  assign mode.nested = nested_en;
  assign mode.high   = high_mode;

  pmu_range_decode #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_range (
    .mode        (mode),
    .hpmn        (hpmn),
    .num_impl    (num_impl),
    .reserved    (reserved_mask),
    .implemented (impl_mask),
    .access      (access_mask),
    .count_field (count_field)
  );

  pmu_irq_gate #(.CNT_W(CNT_W)) u_gate (
    .ovf      (ovf_status),
    .inten    (int_enable),
    .reserved (reserved_mask),
    .low_en   (low_gen_en),
    .high_en  (high_gen_en),
    .pending  (pending),
    .any      (any_pending)
  );

  pmu_irq_level u_level (
    .clk           (clk),
    .rst_n         (rst_n),
    .level_in      (any_pending),
    .irq_level     (irq_level),
    .level_changed (level_changed)
  );

  AST_RSV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!nested_en || hpmn >= num_impl) |-> reserved_mask == '0); // R1
  AST_CYCLE_NEVER_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    !reserved_mask[CNT_W-1]); // R2
  AST_LOW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !low_gen_en |-> (pending & ~reserved_mask) == '0); // R4
  AST_HIGH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !high_gen_en |-> (pending & reserved_mask) == '0); // R5
  AST_ACCESS_EXCLUDES_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    (nested_en && !high_mode) |-> (access_mask & reserved_mask) == '0); // R7
  AST_ACCESS_IN_IMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (access_mask & ~impl_mask) == '0); // R6
endmodule

// File: tb/tb_pmu_ovf_irq_ctrl.sv
module tb_pmu_ovf_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nested_en = 1'b0, high_mode = 1'b0;
  logic [4:0]  hpmn = '0, num_impl = '0;
  logic        low_gen_en = 1'b0, high_gen_en = 1'b0;
  logic [31:0] ovf_status = '0, int_enable = '0;
  logic [31:0] reserved_mask, access_mask;
  logic [4:0]  count_field;
  logic        irq_level, level_changed;

  int checks = 0, failures = 0;
  bit done = 0;
  logic prev_irq = 1'b0;

  typedef struct {
    logic [31:0] rsv;
    logic [31:0] acc;
    logic [4:0]  cnt;
    logic        irq;
    logic        chg;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  pmu_ovf_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .nested_en(nested_en), .high_mode(high_mode),
    .hpmn(hpmn), .num_impl(num_impl), .low_gen_en(low_gen_en),
    .high_gen_en(high_gen_en), .ovf_status(ovf_status), .int_enable(int_enable),
    .reserved_mask(reserved_mask), .access_mask(access_mask),
    .count_field(count_field), .irq_level(irq_level), .level_changed(level_changed)
  );

  task automatic chk(input string tag, input string field,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, field, act, exp);
    end
  endtask

  task automatic apply(input logic ne, input logic hm, input int hp, input int n,
                       input logic le, input logic he, input logic [31:0] ov,
                       input logic [31:0] ie, input string tag);
    exp_t e;
    logic [31:0] impl, rsv, pend;
    logic lvl;
    @(negedge clk);
    nested_en = ne; high_mode = hm; hpmn = 5'(hp); num_impl = 5'(n);
    low_gen_en = le; high_gen_en = he; ovf_status = ov; int_enable = ie;
    impl = 32'h8000_0000;
    rsv = '0;
    for (int i = 0; i < 31; i++) begin
      if (i < n) impl[i] = 1'b1;
      if (ne && hp < n && i >= hp && i < n) rsv[i] = 1'b1;
    end
    pend = ov & ie & ((rsv & {32{he}}) | (~rsv & {32{le}}));
    lvl = |pend;
    e.rsv = rsv;
    e.acc = (ne && !hm) ? (impl & ~rsv) : impl;
    e.cnt = (ne && !hm) ? 5'(hp) : 5'(n);
    e.irq = lvl;
    e.chg = lvl != prev_irq;
    prev_irq = lvl;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk(e.tag, "reserved_mask", reserved_mask, e.rsv);
        chk(e.tag, "access_mask", access_mask, e.acc);
        chk(e.tag, "count_field", {27'b0, count_field}, {27'b0, e.cnt});
        chk(e.tag, "irq_level", {31'b0, irq_level}, {31'b0, e.irq});
        chk(e.tag, "level_changed", {31'b0, level_changed}, {31'b0, e.chg});
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    // R10: pending everywhere while reset is held
    ovf_status = '1; int_enable = '1; low_gen_en = 1'b1; high_gen_en = 1'b1;
    num_impl = 5'd6;
    repeat (3) @(negedge clk);
    chk("R10", "irq_level", {31'b0, irq_level}, 32'd0);
    chk("R10", "level_changed", {31'b0, level_changed}, 32'd0);
    ovf_status = '0;
    @(negedge clk);
    rst_n = 1'b1;

    apply(0, 0, 2, 6, 1, 1, 32'h0000_0004, 32'hFFFF_FFFF, "R1_nested_off");
    apply(0, 0, 2, 6, 1, 1, 32'h0000_0004, 32'hFFFF_FFFF, "R9_hold");
    apply(1, 0, 2, 6, 1, 1, 32'h0, 32'h0, "R2_R7_R8_split");
    apply(1, 0, 6, 6, 1, 1, 32'h0, 32'h0, "R1_hpmn_eq_n");
    apply(1, 0, 9, 6, 1, 1, 32'h0, 32'h0, "R1_hpmn_gt_n");
    apply(1, 0, 0, 6, 1, 1, 32'h0, 32'h0, "R2_hpmn_zero");
    apply(1, 0, 30, 31, 1, 1, 32'h0, 32'h0, "R2_top_counter");
    apply(1, 1, 2, 6, 1, 1, 32'h0, 32'h0, "R6_R8_high_mode");
    apply(0, 0, 0, 0, 1, 1, 32'h0, 32'h0, "R6_no_general");
    apply(1, 0, 2, 6, 0, 1, 32'h0000_0001, 32'hFFFF_FFFF, "R4_low_off_gen");
    apply(1, 0, 2, 6, 0, 1, 32'h8000_0000, 32'hFFFF_FFFF, "R4_low_off_cycle");
    apply(1, 0, 2, 6, 0, 1, 32'h8000_0008, 32'hFFFF_FFFF, "R5_high_on_rsv");
    apply(1, 0, 2, 6, 0, 0, 32'h8000_0008, 32'hFFFF_FFFF, "R5_high_off_rsv");
    apply(1, 0, 2, 6, 1, 0, 32'h0000_0009, 32'hFFFF_FFFF, "R4_low_on");
    apply(1, 0, 2, 6, 1, 1, 32'h0000_0002, 32'h0000_0004, "R3_enable_mask");
    apply(1, 0, 2, 6, 1, 1, 32'h0000_0002, 32'h0000_0006, "R3_enable_match");
    apply(1, 0, 2, 6, 1, 1, 32'h0000_0002, 32'h0000_0006, "R9_hold_high");
    apply(1, 1, 6, 6, 0, 1, 32'h0000_0001, 32'hFFFF_FFFF, "R1_R4_no_split");
    apply(1, 0, 6, 6, 1, 0, 32'h0000_0020, 32'hFFFF_FFFF, "R1_R5_no_split");
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) chk("R3", "queue_drained", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule